// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the sampling strobes for a serial port from the peripheral clock. A 16-bit integer divisor sets the base period of the sampling strobe. An optional rational prescale then lengthens the average period by the factor (1 + A/M), where M is a multiplier field and A is an add field. The block emits a sampling strobe at sixteen times the baud rate and a bit strobe once per sixteen sampling strobes. Together these give an average baud rate of clk / (16 × D × (1 + A/M)).

Software programs the block through a four-address byte-wide register window. The two divisor bytes can be written only while an access-enable bit in the line-control byte is set. The fractional fields sit together in one byte. Any write that changes the divisor or the fractional fields restarts the counters, so the first strobe after the write arrives on a fixed schedule.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, tick16 and bit_tick are 0. The line-control byte reads 0x00, the fractional byte reads 0x10 (M=1, A=0), and the divisor reads low byte 0x01 and high byte 0x00.
- R2: The register addresses are 0 for the divisor low byte, 1 for the divisor high byte, 2 for the fractional byte and 3 for the line-control byte. Bit 7 of the line-control byte is the access enable. Reads of addresses 0 and 1 return the divisor bytes only while access is 1, and return 0 otherwise. Reads are combinational from reg_addr.
- R3: A write to address 0 or 1 while access is 0 leaves the divisor unchanged and does not disturb the running strobe schedule.
- R4: The fractional byte holds M in bits [7:4] and A in bits [3:0]. All 8 written bits read back unchanged.
- R5: When the fractional stage is inactive, tick16 pulses for one cycle every D cycles, where D = 256×high + low.
- R6: A divisor of 0 behaves as a divisor of 1.
- R7: The fractional stage is active when 1 ≤ A < M. An accumulator, cleared at restart, adds A at the end of each base period. When the sum reaches M or more, M is subtracted and that strobe comes after 2D cycles instead of D. The gap between strobes is therefore always D or 2D.
- R8: When A = 0, A ≥ M or M = 0, the fractional stage is bypassed and every gap is D cycles.
- R9: A write to the fractional byte, or a divisor write accepted while access is 1, clears all counters on that clock edge. The first tick16 is then high in the cycle that begins at the D-th edge after the write edge, or the 2D-th edge if that first period is stretched. A write to the line-control byte does not restart anything.
- R10: bit_tick is high in the same cycle as every 16th tick16 counted from the last restart, and never without tick16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tick16 | output | 1 | Oversampling strobe, one cycle wide |
| bit_tick | output | 1 | Bit-rate strobe, one cycle wide |

## Verification
Register reads are combinational and are sampled 1 ns after the address is applied at a falling edge. After a restarting write captured at edge E, the bench counts falling edges from the one that follows E. The first strobe is expected at count D, or 2D if that period is stretched. Every later strobe is expected D or 2D falling edges after the previous one, as a bench model of the accumulator predicts. A strobe that arrives early or is still missing at its due count fails its check. bit_tick is checked in the same sample as each strobe.

// File: rtl/fbg_pkg.sv
`timescale 1ns/1ps
package fbg_pkg;
   localparam int REG_ADDR_W = 2;
   localparam logic [REG_ADDR_W-1:0] ADR_DIV_LO = 2'd0;
   localparam logic [REG_ADDR_W-1:0] ADR_DIV_HI = 2'd1;
   localparam logic [REG_ADDR_W-1:0] ADR_FRAC   = 2'd2;
   localparam logic [REG_ADDR_W-1:0] ADR_LCTRL  = 2'd3;
   localparam int ACCESS_BIT = 7;
   localparam logic [7:0] LCTRL_RST  = 8'h00;
   localparam logic [7:0] FRAC_RST   = 8'h10;
   localparam logic [7:0] DIV_LO_RST = 8'h01;
endpackage

// File: rtl/fbg_regs.sv
`timescale 1ns/1ps
module fbg_regs
   import fbg_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int FRAC_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [7:0]            reg_wdata,
   output logic [7:0]            reg_rdata,
   output logic [DIV_W-1:0]      divisor,
   output logic [FRAC_W-1:0]     mul,
   output logic [FRAC_W-1:0]     add,
   output logic                  restart
);
   logic [7:0] lctrl_q, frac_q, lo_q, hi_view;
   logic       access, wr_lo, wr_hi, wr_frac;

   initial begin
      assert (DIV_W == 8 || DIV_W == 16) else $error("DIV_W must be 8 or 16");
      assert (2 * FRAC_W == 8) else $error("fractional fields must fill one byte");
   end

   assign access  = lctrl_q[ACCESS_BIT];
   assign wr_lo   = reg_we && (reg_addr == ADR_DIV_LO) && access;
   assign wr_frac = reg_we && (reg_addr == ADR_FRAC);
   assign restart = wr_lo || wr_hi || wr_frac;
   assign mul     = frac_q[2*FRAC_W-1:FRAC_W];
   assign add     = frac_q[FRAC_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lctrl_q <= LCTRL_RST;
         frac_q  <= FRAC_RST;
         lo_q    <= DIV_LO_RST;
      end else begin
         if (reg_we && reg_addr == ADR_LCTRL) lctrl_q <= reg_wdata;
         if (wr_frac) frac_q <= reg_wdata;
         if (wr_lo)   lo_q   <= reg_wdata;
      end
   end

   generate
      if (DIV_W > 8) begin : g_hi
         logic [DIV_W-9:0] hi_q;
         assign wr_hi = reg_we && (reg_addr == ADR_DIV_HI) && access;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hi_q <= '0;
            else if (wr_hi) hi_q <= reg_wdata[DIV_W-9:0];
         end
         assign divisor = {hi_q, lo_q};
         assign hi_view = 8'(hi_q);
      end else begin : g_no_hi
         assign wr_hi   = 1'b0;
         assign divisor = lo_q[DIV_W-1:0];
         assign hi_view = 8'h00;
      end
   endgenerate

   always_comb begin
      unique case (reg_addr)
         ADR_DIV_LO: reg_rdata = access ? lo_q : 8'h00;
         ADR_DIV_HI: reg_rdata = access ? hi_view : 8'h00;
         ADR_FRAC:   reg_rdata = frac_q;
         default:    reg_rdata = lctrl_q;
      endcase
   end

   AST_LOCKED_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !access && (reg_addr == ADR_DIV_LO || reg_addr == ADR_DIV_HI))
      |=> $stable(divisor)); // R3
   AST_LCTRL_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADR_LCTRL) |-> !restart); // R9
endmodule

// File: rtl/fbg_divcnt.sv
`timescale 1ns/1ps
module fbg_divcnt #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] divisor,
   output logic             wrap
);
   logic [DIV_W-1:0] cnt_q, last;

   assign last = (divisor == '0) ? '0 : divisor - 1'b1;
   assign wrap = (cnt_q == last) && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (restart)      cnt_q <= '0;
      else if (cnt_q == last) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= last); // R6
   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt_q == '0); // R9
endmodule

// File: rtl/fbg_frac.sv
`timescale 1ns/1ps
module fbg_frac #(
   parameter int FRAC_W = 4,
   parameter bit ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              wrap,
   input  logic [FRAC_W-1:0] mul,
   input  logic [FRAC_W-1:0] add,
   output logic              fire
);
   generate
      if (ENABLE) begin : g_frac
         logic [FRAC_W-1:0] acc_q;
         logic              extra_q, active, carry;
         logic [FRAC_W:0]   sum;

         assign active = (add != '0) && (add < mul);
         assign sum    = {1'b0, acc_q} + {1'b0, add};
         assign carry  = sum >= {1'b0, mul};
         assign fire   = wrap && (!active || extra_q || !carry);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q   <= '0;
               extra_q <= 1'b0;
            end else if (restart) begin
               acc_q   <= '0;
               extra_q <= 1'b0;
            end else if (wrap && active) begin
               if (extra_q) begin
                  extra_q <= 1'b0;
               end else if (carry) begin
                  acc_q   <= FRAC_W'(sum - {1'b0, mul});
                  extra_q <= 1'b1;
               end else begin
                  acc_q   <= sum[FRAC_W-1:0];
               end
            end
         end

         AST_ACC_BELOW_MUL: assert property (@(posedge clk) disable iff (!rst_n)
            active |-> acc_q < mul); // R7
         AST_EXTRA_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            extra_q |-> active); // R8
         AST_SINGLE_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
            (extra_q && wrap) |=> !extra_q); // R7
      end else begin : g_plain
         assign fire = wrap;
      end
   endgenerate
endmodule

// File: rtl/fbg_ticks.sv
`timescale 1ns/1ps
module fbg_ticks #(
   parameter int OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic fire,
   output logic tick16,
   output logic bit_tick
);
   localparam int SUB_W = $clog2(OVERSAMPLE);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

   logic [SUB_W-1:0] sub_q;

   initial assert (OVERSAMPLE >= 2 && (OVERSAMPLE & (OVERSAMPLE - 1)) == 0)
      else $error("OVERSAMPLE must be a power of two");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick16 <= 1'b0; bit_tick <= 1'b0; sub_q <= '0;
      end else if (restart) begin
         tick16 <= 1'b0; bit_tick <= 1'b0; sub_q <= '0;
      end else begin
         tick16   <= fire;
         bit_tick <= fire && (sub_q == SUB_LAST);
         if (fire) sub_q <= sub_q + 1'b1;
      end
   end
endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
module frac_baud_gen
   import fbg_pkg::*;
#(
   parameter int DIV_W      = 16,
   parameter int FRAC_W     = 4,
   parameter int OVERSAMPLE = 16,
   parameter bit FRAC_EN    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       tick16,
   output logic       bit_tick
);
   logic [DIV_W-1:0]  divisor;
   logic [FRAC_W-1:0] mul, add;
   logic              restart, wrap, fire;

   fbg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .divisor(divisor),
      .mul(mul), .add(add), .restart(restart));

   fbg_divcnt #(.DIV_W(DIV_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .restart(restart), .divisor(divisor), .wrap(wrap));

   fbg_frac #(.FRAC_W(FRAC_W), .ENABLE(FRAC_EN)) u_frac (
      .clk(clk), .rst_n(rst_n), .restart(restart), .wrap(wrap),
      .mul(mul), .add(add), .fire(fire));

   fbg_ticks #(.OVERSAMPLE(OVERSAMPLE)) u_ticks (
      .clk(clk), .rst_n(rst_n), .restart(restart), .fire(fire),
      .tick16(tick16), .bit_tick(bit_tick));

   AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> tick16); // R10
   AST_QUIET_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick16); // R9
endmodule

// File: tb/tb_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_frac_baud_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic we = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic tick16, bit_tick;

   always #2.5 clk = ~clk;

   frac_baud_gen dut (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .tick16(tick16), .bit_tick(bit_tick));

   int n_chk = 0, n_bad = 0;
   int cfg_d, cfg_mul, cfg_add, m_acc, exp_int, since, nt;
   bit cfg_act;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle();
      we = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic poke(input logic [1:0] a, input logic [7:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      idle();
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      addr = a; #1; d = rdata;
   endtask

   function automatic void plan_next();
      if (cfg_act) begin
         int s;
         s = m_acc + cfg_add;
         if (s >= cfg_mul) begin exp_int = 2 * cfg_d; m_acc = s - cfg_mul; end
         else begin exp_int = cfg_d; m_acc = s; end
      end else begin
         exp_int = cfg_d;
      end
   endfunction

   task automatic track(input int n_ticks, input string req);
      int got = 0;
      while (got < n_ticks) begin
         @(posedge clk); @(negedge clk);
         idle();
         since++;
         if (tick16 || since >= exp_int) begin
            chk(tick16 && since == exp_int, (nt == 0) ? "R9" : req, since, exp_int);
            nt++;
            chk(bit_tick == (nt % 16 == 0), "R10", int'(bit_tick), int'(nt % 16 == 0));
            since = 0;
            plan_next();
            got++;
         end
      end
   endtask

   task automatic apply(input logic [7:0] lo, input logic [7:0] hi,
                        input logic [3:0] mul, input logic [3:0] add,
                        input int n_ticks, input string req);
      logic [7:0] rb;
      poke(2'd3, 8'h80);
      poke(2'd0, lo);
      poke(2'd1, hi);
      poke(2'd3, 8'h03);
      we = 1'b1; addr = 2'd2; wdata = {mul, add};
      cfg_d   = (int'(hi) * 256 + int'(lo) == 0) ? 1 : int'(hi) * 256 + int'(lo);
      cfg_mul = int'(mul); cfg_add = int'(add);
      cfg_act = (add != 0) && (add < mul);
      m_acc = 0; nt = 0; since = -1;
      plan_next();
      track(n_ticks, req);
      peek(2'd2, rb);
      chk(rb == {mul, add}, "R4", int'(rb), int'({mul, add}));
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      logic [7:0] rb;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk(tick16 == 1'b0 && bit_tick == 1'b0, "R1", int'({tick16, bit_tick}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      peek(2'd3, rb); chk(rb == 8'h00, "R1", rb, 8'h00);
      peek(2'd2, rb); chk(rb == 8'h10, "R1", rb, 8'h10);
      peek(2'd0, rb); chk(rb == 8'h00, "R2", rb, 8'h00);
      poke(2'd3, 8'h80);
      peek(2'd0, rb); chk(rb == 8'h01, "R1", rb, 8'h01);
      peek(2'd1, rb); chk(rb == 8'h00, "R1", rb, 8'h00);

      // directed corner cases
      apply(8'd5, 8'd0, 4'd1, 4'd0, 20, "R5");
      apply(8'd44, 8'd1, 4'd15, 4'd0, 3, "R5");
      apply(8'd0, 8'd0, 4'd1, 4'd0, 40, "R6");
      apply(8'd3, 8'd0, 4'd3, 4'd1, 40, "R7");
      apply(8'd0, 8'd0, 4'd3, 4'd2, 40, "R6");
      apply(8'd4, 8'd0, 4'd5, 4'd7, 20, "R8");
      apply(8'd4, 8'd0, 4'd0, 4'd3, 20, "R8");
      apply(8'd4, 8'd0, 4'd6, 4'd6, 20, "R8");

      // R3: locked divisor writes while running, schedule must continue
      apply(8'd6, 8'd0, 4'd4, 4'd1, 5, "R7");
      we = 1'b1; addr = 2'd0; wdata = 8'd2;
      track(6, "R3");
      we = 1'b1; addr = 2'd1; wdata = 8'd9;
      track(6, "R3");
      poke(2'd3, 8'h83);
      peek(2'd0, rb); chk(rb == 8'd6, "R3", rb, 6);
      peek(2'd1, rb); chk(rb == 8'd0, "R3", rb, 0);
      poke(2'd3, 8'h03);
      peek(2'd0, rb); chk(rb == 8'h00, "R2", rb, 0);
      peek(2'd3, rb); chk(rb == 8'h03, "R2", rb, 3);

      // constrained random configurations
      for (int i = 0; i < 12; i++) begin
         logic [7:0] lo;
         logic [3:0] m, a;
         lo = 8'($urandom % 13);
         m  = 4'($urandom % 16);
         a  = 4'($urandom % 16);
         apply(lo, 8'd0, m, a, 34, ((a != 0) && (a < m)) ? "R7" : "R8");
      end
      finish_run();
   end
endmodule